// File: doc/BRIEF.md
# Gain-Ranged Pixel Sample Normalizer

This block sits after a pixel converter whose analog front end applies one of four gains to each pixel before conversion. Every incoming beat carries a 10-bit conversion result and a 2-bit range code. The range code says which gain the pixel received. The block removes that gain with a right shift. It does not drop the bits that fall off the bottom: they land in three fractional bits. The result is a 13-bit linear value in a 10.3 fixed-point format, and it is registered onto a valid/ready output stream.

The range code can reach the block ahead of the sample it belongs to. A small delay line holds recent codes, and a lag setting picks which one is applied, so each sample is paired with its own code. The delay line advances only on accepted beats. A bypass setting turns the range extension off, and every sample is then treated as if it had unit gain.

The output register is controlled by a two-state machine. In state EMPTY the register holds nothing. In state FULL it holds an unread result. The transitions are:
- fill: a beat is accepted while in EMPTY, so the state goes to FULL.
- drain: the output is taken with no new beat accepted, so the state goes from FULL back to EMPTY.
- refill: a beat is accepted while in FULL, in the same cycle the output is taken, so the state stays FULL and the register loads the new result.
- stall: in FULL the output is not taken, so the register holds.

Top module: `pixel_range_norm`

## Requirements
- R1: The output equals the 13-bit integer `{in_adc, 3'b000} >> s`. The shift s is 3, 2, 1 or 0 for codes 00 (gain x8), 01 (x4), 10 (x2) and 11 (x1). An output is therefore never larger than `{in_adc, 3'b000}`.
- R2: The shifted-out bits are kept in the three fractional LSBs. For example, sample 819 (1100110011) with code 00 gives 0001100110.011, which is integer 819.
- R3: With code 11 the output is the sample followed by fractional bits 000, that is sample × 8.
- R4: When `cfg_bypass` is 1, the output is sample × 8 (fractional bits 000) whatever the code.
- R5: With `cfg_lag` = L (0..3), the code applied to the n-th accepted sample is the code presented with the (n−L)-th accepted beat. L = 0 uses the code of the same beat.
- R6: After reset the code delay line holds code 11. A sample whose lagged code comes from before reset is therefore scaled as x1.
- R7: After synchronous reset (`rst_n` low at a clock edge), `out_valid` is 0 and `in_ready` is 1.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` hold and `in_ready` is 0. The offered beat is not accepted.
- R9: A beat accepted at a clock edge (`in_valid` and `in_ready` both 1) appears on `out_valid`/`out_data` right after that edge. A drain and a refill can happen at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_bypass | input | 1 | 1 = treat every sample as unit gain |
| cfg_lag | input | 2 | Beats by which the range code is delayed (0..3) |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat can be taken |
| in_adc | input | 10 | Converter sample |
| in_code | input | 2 | Gain-range code |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 13 | Normalized value, 10.3 fixed point |

## Verification
A result is due one clock edge after its beat is accepted. The bench therefore drives a beat at a falling edge and compares the output at the next falling edge, after exactly one rising edge. Range-code lag is measured in accepted beats, not cycles, so the lag test spaces its beats with idle cycles and still expects the codes from L beats back. The stall test holds `out_ready` low for several cycles and checks the output at each falling edge. It then releases `out_ready` with a beat still pending and expects the new result one edge later.

// File: rtl/prn_pkg.sv
package prn_pkg;
    localparam int ADC_W   = 10;
    localparam int FRAC_W  = 3;
    localparam int CODE_W  = 2;
    localparam int MAX_LAG = 3;
    localparam int LAG_W   = $clog2(MAX_LAG + 1);
    localparam int OUT_W   = ADC_W + FRAC_W;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } ostate_t;
endpackage

// File: rtl/prn_code_align.sv
module prn_code_align
    import prn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic [LAG_W-1:0]  lag,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] code_out
);
    logic [CODE_W-1:0] tap [MAX_LAG+1];

    assign tap[0] = code_in;

    for (genvar g = 1; g <= MAX_LAG; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n)       tap[g] <= '1;
            else if (advance) tap[g] <= tap[g-1];
        end
    end

    always_comb begin
        if (int'(lag) > MAX_LAG) code_out = tap[MAX_LAG];
        else                     code_out = tap[lag];
    end
endmodule

// File: rtl/prn_shift.sv
module prn_shift
    import prn_pkg::*;
(
    input  logic              bypass,
    input  logic [ADC_W-1:0]  sample,
    input  logic [CODE_W-1:0] code,
    output logic [OUT_W-1:0]  value
);
    localparam logic [CODE_W-1:0] UNITY = '1;

    logic [CODE_W-1:0] amount;

    always_comb begin
        amount = bypass ? '0 : (UNITY - code);
        value  = {sample, {FRAC_W{1'b0}}} >> amount;
    end

    always_comb begin
        if (bypass) assert (value[FRAC_W-1:0] == '0)
            else $error("p_frac_zero_r4: bypass left fractional bits set");
    end
endmodule

// File: rtl/prn_out_stage.sv
module prn_out_stage
    import prn_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [OUT_W-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_data
);
    ostate_t state, state_nxt;
    logic    in_fire;

    assign in_fire = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_EMPTY: if (in_fire) state_nxt = ST_FULL;
            ST_FULL:  if (out_ready && !in_fire) state_nxt = ST_EMPTY;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_EMPTY: begin out_valid = 1'b0; in_ready = 1'b1;      end
            ST_FULL:  begin out_valid = 1'b1; in_ready = out_ready; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       out_data <= '0;
        else if (in_fire) out_data <= in_data;
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    p_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !in_valid |=> !out_valid);
endmodule

// File: rtl/pixel_range_norm.sv
module pixel_range_norm
    import prn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_bypass,
    input  logic [LAG_W-1:0]  cfg_lag,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADC_W-1:0]  in_adc,
    input  logic [CODE_W-1:0] in_code,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [OUT_W-1:0]  out_data
);
    logic [CODE_W-1:0] aligned_code;
    logic [OUT_W-1:0]  norm_value;
    logic              accept;

    assign accept = in_valid && in_ready;

    prn_code_align u_align (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (accept),
        .lag      (cfg_lag),
        .code_in  (in_code),
        .code_out (aligned_code)
    );

    prn_shift u_shift (
        .bypass (cfg_bypass),
        .sample (in_adc),
        .code   (aligned_code),
        .value  (norm_value)
    );

    prn_out_stage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (norm_value),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    p_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_data <= $past({in_adc, {FRAC_W{1'b0}}}));

    p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept && cfg_bypass |=> out_data == $past({in_adc, {FRAC_W{1'b0}}}));
endmodule

// File: tb/pixel_range_norm_tb_top.sv
module pixel_range_norm_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 11;

    // each entry: {sample[9:0], code[1:0], expected[12:0]}
    localparam logic [24:0] VEC [NVEC] = '{
        {10'd819,  2'b00, 13'd819},
        {10'd819,  2'b11, 13'd6552},
        {10'd1023, 2'b00, 13'd1023},
        {10'd1023, 2'b01, 13'd2046},
        {10'd1023, 2'b10, 13'd4092},
        {10'd1023, 2'b11, 13'd8184},
        {10'd0,    2'b00, 13'd0},
        {10'd1,    2'b00, 13'd1},
        {10'd1,    2'b01, 13'd2},
        {10'd1,    2'b10, 13'd4},
        {10'd512,  2'b00, 13'd512}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_bypass = 1'b0;
    logic [1:0]  cfg_lag = 2'd0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [9:0]  in_adc = '0;
    logic [1:0]  in_code = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [12:0] out_data;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pixel_range_norm dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_bypass(cfg_bypass), .cfg_lag(cfg_lag),
        .in_valid(in_valid), .in_ready(in_ready), .in_adc(in_adc), .in_code(in_code),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    function automatic int ref_norm(input int adc, input int code, input bit byp);
        int s = byp ? 0 : 3 - code;
        return (adc * 8) >> s;
    endfunction

    task automatic beat(input int adc, input int code);
        @(negedge clk);
        in_adc   = adc[9:0];
        in_code  = code[1:0];
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        do_reset();
        // R7: reset state
        check("R7 out_valid after reset", out_valid, 0);
        check("R7 in_ready after reset", in_ready, 1);

        // table of vectors, lag 0, no bypass (R1, R2, R3, R9)
        for (int i = 0; i < NVEC; i++) begin
            beat(int'(VEC[i][24:15]), int'(VEC[i][14:13]));
            check("R9 out_valid one edge after accept", out_valid, 1);
            if (VEC[i][24:15] == 10'd819 && VEC[i][14:13] == 2'b00)
                check("R2 fractional bits kept", out_data, int'(VEC[i][12:0]));
            else if (VEC[i][14:13] == 2'b11)
                check("R3 unit gain", out_data, int'(VEC[i][12:0]));
            else
                check("R1 table vector", out_data, int'(VEC[i][12:0]));
        end

        // exhaustive sweep of every sample and code (R1)
        begin
            int bad = 0;
            for (int a = 0; a < 1024; a++) begin
                for (int c = 0; c < 4; c++) begin
                    beat(a, c);
                    if (out_data != 13'(ref_norm(a, c, 1'b0))) begin
                        if (bad == 0)
                            $display("FAIL R1 sweep adc=%0d code=%0d: actual=%0d expected=%0d",
                                     a, c, out_data, ref_norm(a, c, 1'b0));
                        bad++;
                    end
                end
            end
            n_checks++;
            if (bad != 0) n_errors++;
        end

        // bypass (R4)
        cfg_bypass = 1'b1;
        beat(1000, 0);
        check("R4 bypass code 00", out_data, 8000);
        beat(3, 1);
        check("R4 bypass code 01", out_data, 24);
        cfg_bypass = 1'b0;

        // lag 2 after reset (R5, R6)
        cfg_lag = 2'd2;
        do_reset();
        beat(64, 0);
        check("R6 first beat uses reset code x1", out_data, 512);
        beat(64, 1);
        check("R6 second beat uses reset code x1", out_data, 512);
        beat(64, 2);
        check("R5 third beat uses code of beat 1 (00)", out_data, 64);
        repeat (3) @(negedge clk);
        beat(64, 3);
        check("R5 fourth beat uses code of beat 2 (01)", out_data, 128);
        cfg_lag = 2'd3;
        beat(64, 0);
        check("R5 lag 3 uses code of beat 2 (01)", out_data, 128);
        cfg_lag = 2'd0;

        // stall and hold (R8), then a refill and a drain at one edge (R9)
        do_reset();
        @(negedge clk);
        out_ready = 1'b0;
        in_adc = 10'd100; in_code = 2'b11; in_valid = 1'b1;
        @(negedge clk);
        in_adc = 10'd200; in_code = 2'b00;
        check("R8 first result present", out_data, 800);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R8 data held during stall", out_data, 800);
            check("R8 valid held during stall", out_valid, 1);
            check("R8 in_ready low during stall", in_ready, 0);
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 refill while draining", out_data, 200);
        check("R9 still valid after refill", out_valid, 1);
        @(negedge clk);
        check("R9 drain empties output", out_valid, 0);

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule